// File: doc/BRIEF.md
# Multicycle Instruction Step Controller

This block is the control sequencer for a processor that executes each instruction over several short clock cycles instead of one long cycle. It covers sixteen instructions: six register-to-register ALU operations, five ALU operations with an immediate operand, a word load and a word store, two conditional branches and an unconditional jump. Every instruction starts with the same two steps: fetch, then decode with register read and branch/jump target preparation. After that the instruction class decides how many more steps follow. A jump finishes in decode. A branch finishes after its compare step. ALU and store instructions finish after a fourth step, and a load alone uses a fifth step to write back the loaded word.

The controller watches the opcode and function fields held in the instruction register, along with the ALU zero flag. In each step it drives the datapath enables: PC write, instruction register load, register file write, and data memory read and write. It also drives the multiplexer selects and the ALU function code. A one-cycle retire pulse marks the last step of every legal instruction. An unrecognised encoding is abandoned after decode with no state written. The datapath arithmetic itself is outside this block.

Top module: `mc_step_ctrl`

## Requirements
- R1: While `rst` is high every output is 0. The first cycle after `rst` falls is a fetch step, and reset taken in the middle of an instruction abandons it.
- R2: In the fetch step `ir_load` and `pc_write` are 1 and `pc_src` is 00 (PC plus four). No other step loads the instruction register, and `pc_src` is 00 in every cycle where `pc_write` is 0.
- R3: The jump (opcode 0x02) takes 2 cycles. In its decode step it asserts `pc_write` with `pc_src` 01 (jump target) and retires there.
- R4: Register ALU instructions (opcode 0x00 with funct 0x20, 0x22, 0x24, 0x25, 0x26, 0x2a) and immediate ALU instructions (opcodes 0x08, 0x0a, 0x0c, 0x0d, 0x0e) take 4 cycles. They assert `reg_write` with `wb_src` 0 in the fourth cycle.
- R5: In the execute step `alu_op` is ADD 0000, SUB 0010, AND 0100, OR 0101, XOR 0110 or SLT 1010, chosen by funct (register forms), by opcode (addi ADD, slti SLT, andi AND, ori OR, xori XOR), ADD for load and store, and SUB for branches. In that step `alu_b_imm` is 1 for immediate, load and store forms. Outside execute both are 0.
- R6: Outside reset, `reg_dst` is 1 exactly for a legal register ALU instruction. `ext_sign` is 1 exactly for opcodes 0x08, 0x0a, 0x23, 0x2b, 0x04, 0x05.
- R7: A load (0x23) takes 5 cycles: `mem_read` in the fourth, then `reg_write` with `wb_src` 1 in the fifth.
- R8: A store (0x2b) takes 4 cycles, with `mem_write` in the fourth and no register write.
- R9: Branches (0x04 equal, 0x05 not equal) take 3 cycles. In the third cycle `pc_write` is 1 with `pc_src` 10 when the condition holds on `alu_zero`, and 0 otherwise.
- R10: `retire` is high for exactly the last cycle of each legal instruction, and the next cycle is a fetch step.
- R11: Any other opcode, or opcode 0x00 with another funct, takes 2 cycles with no write enable after fetch and no retire.
- R12: `reg_write` and `mem_write` are never high together, and `mem_read` is high only in a load's memory step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| funct | input | 6 | Function field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| ir_load | output | 1 | Load the instruction register |
| pc_write | output | 1 | Write the program counter |
| pc_src | output | 2 | Next-PC select: 00 incremented, 01 jump target, 10 branch target |
| reg_write | output | 1 | Register file write enable |
| reg_dst | output | 1 | Destination is the rd field (1) or the rt field (0) |
| wb_src | output | 1 | Write-back data from memory (1) or the ALU result register (0) |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |
| alu_b_imm | output | 1 | Second ALU operand is the extended immediate |
| ext_sign | output | 1 | Immediate is sign-extended (1) or zero-extended (0) |
| alu_op | output | 4 | ALU function code |
| retire | output | 1 | Last step of an instruction |

## Verification
The functions most likely to collide are the retire pulse and a PC update that is not the fetch increment. A jump writes its target and retires in the same decode cycle, and a taken branch writes its target and retires in the same compare cycle. These cycles are provoked by sweeping every opcode, every funct under opcode 0x00, and both values of the zero flag, so that each branch is seen both taken and not taken. The bench judges the full output vector in every cycle against a per-step expectation built from the requirements, including the fetch that must follow every retire.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 4;
  localparam int PCS_W = 2;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_LDONE  = 3'd4
  } step_e;

  typedef enum logic [2:0] {
    IC_BAD, IC_RALU, IC_IALU, IC_LOAD, IC_STORE, IC_BRANCH, IC_JUMP
  } iclass_e;

  localparam logic [ALU_W-1:0] ALU_ADD = 4'b0000;
  localparam logic [ALU_W-1:0] ALU_SUB = 4'b0010;
  localparam logic [ALU_W-1:0] ALU_AND = 4'b0100;
  localparam logic [ALU_W-1:0] ALU_OR  = 4'b0101;
  localparam logic [ALU_W-1:0] ALU_XOR = 4'b0110;
  localparam logic [ALU_W-1:0] ALU_SLT = 4'b1010;

  localparam logic [PCS_W-1:0] PC_SEQ = 2'b00;
  localparam logic [PCS_W-1:0] PC_JMP = 2'b01;
  localparam logic [PCS_W-1:0] PC_BR  = 2'b10;

  localparam logic [OP_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OP_W-1:0] OPC_JMP  = 6'h02;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OP_W-1:0] OPC_BNE  = 6'h05;
  localparam logic [OP_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OP_W-1:0] OPC_SLTI = 6'h0a;
  localparam logic [OP_W-1:0] OPC_ANDI = 6'h0c;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'h0d;
  localparam logic [OP_W-1:0] OPC_XORI = 6'h0e;
  localparam logic [OP_W-1:0] OPC_LDW  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STW  = 6'h2b;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR = 6'h26;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2a;

  typedef struct packed {
    iclass_e          cls;
    logic             use_rd;
    logic             sext;
    logic             b_imm;
    logic             br_ne;
    logic [ALU_W-1:0] alu;
  } idec_t;
endpackage

// File: rtl/mc_idecode.sv
module mc_idecode
  import mc_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [FN_W-1:0] fn,
  output idec_t           dec
);
  always_comb begin
    dec        = '0;
    dec.cls    = IC_BAD;
    dec.alu    = ALU_ADD;
    case (op)
      OPC_REG: begin
        dec.cls    = IC_RALU;
        dec.use_rd = 1'b1;
        case (fn)
          FN_ADD:  dec.alu = ALU_ADD;
          FN_SUB:  dec.alu = ALU_SUB;
          FN_AND:  dec.alu = ALU_AND;
          FN_OR:   dec.alu = ALU_OR;
          FN_XOR:  dec.alu = ALU_XOR;
          FN_SLT:  dec.alu = ALU_SLT;
          default: begin
            dec.cls    = IC_BAD;
            dec.use_rd = 1'b0;
          end
        endcase
      end
      OPC_ADDI: begin dec.cls = IC_IALU; dec.sext = 1'b1; dec.b_imm = 1'b1; dec.alu = ALU_ADD; end
      OPC_SLTI: begin dec.cls = IC_IALU; dec.sext = 1'b1; dec.b_imm = 1'b1; dec.alu = ALU_SLT; end
      OPC_ANDI: begin dec.cls = IC_IALU; dec.b_imm = 1'b1; dec.alu = ALU_AND; end
      OPC_ORI:  begin dec.cls = IC_IALU; dec.b_imm = 1'b1; dec.alu = ALU_OR;  end
      OPC_XORI: begin dec.cls = IC_IALU; dec.b_imm = 1'b1; dec.alu = ALU_XOR; end
      OPC_LDW:  begin dec.cls = IC_LOAD;  dec.sext = 1'b1; dec.b_imm = 1'b1; dec.alu = ALU_ADD; end
      OPC_STW:  begin dec.cls = IC_STORE; dec.sext = 1'b1; dec.b_imm = 1'b1; dec.alu = ALU_ADD; end
      OPC_BEQ:  begin dec.cls = IC_BRANCH; dec.sext = 1'b1; dec.alu = ALU_SUB; end
      OPC_BNE:  begin dec.cls = IC_BRANCH; dec.sext = 1'b1; dec.alu = ALU_SUB; dec.br_ne = 1'b1; end
      OPC_JMP:  dec.cls = IC_JUMP;
      default:  dec.cls = IC_BAD;
    endcase
  end
endmodule

// File: rtl/mc_stepfsm.sv
module mc_stepfsm
  import mc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  iclass_e cls,
  output step_e   state
);
  step_e nxt;

  always_comb begin
    nxt = ST_FETCH;
    case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = (cls == IC_JUMP || cls == IC_BAD) ? ST_FETCH : ST_EXEC;
      ST_EXEC:   nxt = (cls == IC_BRANCH) ? ST_FETCH : ST_MEM;
      ST_MEM:    nxt = (cls == IC_LOAD) ? ST_LDONE : ST_FETCH;
      ST_LDONE:  nxt = ST_FETCH;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end

  // Checker: cycles spent since the last fetch step
  logic [CNT_W-1:0] since_fetch;
  always_ff @(posedge clk) begin
    if (rst || nxt == ST_FETCH) since_fetch <= '0;
    else                        since_fetch <= since_fetch + 1'b1;
  end

  // R10: no instruction lasts more than five cycles
  a_r10_step_bound: assert property (@(posedge clk) disable iff (rst)
    since_fetch <= 3'd4);
  // R7: the load completion step only follows the memory step
  a_r7_ldone_after_mem: assert property (@(posedge clk) disable iff (rst)
    state == ST_LDONE |-> $past(state) == ST_MEM);
  // R1: fetch is always followed by decode
  a_r1_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH |=> state == ST_DECODE);
endmodule

// File: rtl/mc_ctlout.sv
module mc_ctlout
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  step_e            state,
  input  idec_t            dec,
  input  logic             alu_zero,
  output logic             ir_load,
  output logic             pc_write,
  output logic [PCS_W-1:0] pc_src,
  output logic             reg_write,
  output logic             reg_dst,
  output logic             wb_src,
  output logic             mem_read,
  output logic             mem_write,
  output logic             alu_b_imm,
  output logic             ext_sign,
  output logic [ALU_W-1:0] alu_op,
  output logic             retire
);
  logic taken;
  assign taken = dec.br_ne ? !alu_zero : alu_zero;

  always_comb begin
    ir_load   = 1'b0;
    pc_write  = 1'b0;
    pc_src    = PC_SEQ;
    reg_write = 1'b0;
    wb_src    = 1'b0;
    mem_read  = 1'b0;
    mem_write = 1'b0;
    alu_b_imm = 1'b0;
    alu_op    = '0;
    retire    = 1'b0;
    reg_dst   = dec.use_rd;
    ext_sign  = dec.sext;
    case (state)
      ST_FETCH: begin
        ir_load  = 1'b1;
        pc_write = 1'b1;
      end
      ST_DECODE: begin
        if (dec.cls == IC_JUMP) begin
          pc_write = 1'b1;
          pc_src   = PC_JMP;
          retire   = 1'b1;
        end
      end
      ST_EXEC: begin
        alu_op    = dec.alu;
        alu_b_imm = dec.b_imm;
        if (dec.cls == IC_BRANCH) begin
          retire = 1'b1;
          if (taken) begin
            pc_write = 1'b1;
            pc_src   = PC_BR;
          end
        end
      end
      ST_MEM: begin
        case (dec.cls)
          IC_RALU, IC_IALU: begin reg_write = 1'b1; retire = 1'b1; end
          IC_STORE:         begin mem_write = 1'b1; retire = 1'b1; end
          IC_LOAD:          mem_read = 1'b1;
          default:          ;
        endcase
      end
      ST_LDONE: begin
        reg_write = 1'b1;
        wb_src    = 1'b1;
        retire    = 1'b1;
      end
      default: ;
    endcase
    if (rst) begin
      ir_load = 1'b0; pc_write = 1'b0; pc_src = PC_SEQ; reg_write = 1'b0;
      reg_dst = 1'b0; wb_src = 1'b0; mem_read = 1'b0; mem_write = 1'b0;
      alu_b_imm = 1'b0; ext_sign = 1'b0; alu_op = '0; retire = 1'b0;
    end
  end

  // R12: register and memory writes are exclusive
  a_r12_no_dual_write: assert property (@(posedge clk) disable iff (rst)
    !(reg_write && mem_write));
  // R2: an instruction load always comes with the sequential PC update
  a_r2_irload_seq: assert property (@(posedge clk) disable iff (rst)
    ir_load |-> (pc_write && pc_src == PC_SEQ && !retire));
  // R10: a retire is followed by a fetch
  a_r10_retire_to_fetch: assert property (@(posedge clk) disable iff (rst)
    retire |=> ir_load);
  // R7: the load write-back comes the cycle after the memory read
  a_r7_read_then_wb: assert property (@(posedge clk) disable iff (rst)
    mem_read |=> (reg_write && wb_src));
endmodule

// File: rtl/mc_step_ctrl.sv
module mc_step_ctrl
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             alu_zero,
  output logic             ir_load,
  output logic             pc_write,
  output logic [PCS_W-1:0] pc_src,
  output logic             reg_write,
  output logic             reg_dst,
  output logic             wb_src,
  output logic             mem_read,
  output logic             mem_write,
  output logic             alu_b_imm,
  output logic             ext_sign,
  output logic [ALU_W-1:0] alu_op,
  output logic             retire
);
  idec_t dec;
  step_e state;

  mc_idecode u_dec (.op(opcode), .fn(funct), .dec(dec));

  mc_stepfsm #(.CNT_W(3)) u_fsm (
    .clk(clk), .rst(rst), .cls(dec.cls), .state(state)
  );

  mc_ctlout u_out (
    .clk(clk), .rst(rst), .state(state), .dec(dec), .alu_zero(alu_zero),
    .ir_load(ir_load), .pc_write(pc_write), .pc_src(pc_src),
    .reg_write(reg_write), .reg_dst(reg_dst), .wb_src(wb_src),
    .mem_read(mem_read), .mem_write(mem_write), .alu_b_imm(alu_b_imm),
    .ext_sign(ext_sign), .alu_op(alu_op), .retire(retire)
  );

  // R1: everything is quiet during reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |-> !(pc_write || reg_write || mem_write || ir_load || retire));
endmodule

// File: tb/mc_step_ctrl_tb.sv
module mc_step_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic       alu_zero = 1'b0;
  logic       ir_load, pc_write, reg_write, reg_dst, wb_src;
  logic       mem_read, mem_write, alu_b_imm, ext_sign, retire;
  logic [1:0] pc_src;
  logic [3:0] alu_op;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_step_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
    .ir_load(ir_load), .pc_write(pc_write), .pc_src(pc_src),
    .reg_write(reg_write), .reg_dst(reg_dst), .wb_src(wb_src),
    .mem_read(mem_read), .mem_write(mem_write), .alu_b_imm(alu_b_imm),
    .ext_sign(ext_sign), .alu_op(alu_op), .retire(retire)
  );

  // class: 0 bad, 1 reg ALU, 2 imm ALU, 3 load, 4 store, 5 branch, 6 jump
  function automatic int klass(input logic [5:0] op, input logic [5:0] fn);
    if (op == 6'h00)
      return (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 ||
              fn == 6'h26 || fn == 6'h2a) ? 1 : 0;
    if (op == 6'h08 || op == 6'h0a || op == 6'h0c || op == 6'h0d || op == 6'h0e) return 2;
    if (op == 6'h23) return 3;
    if (op == 6'h2b) return 4;
    if (op == 6'h04 || op == 6'h05) return 5;
    if (op == 6'h02) return 6;
    return 0;
  endfunction

  function automatic int steps_of(input int k);
    case (k)
      3: return 5;
      1, 2, 4: return 4;
      5: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [3:0] alu_code(input logic [5:0] op, input logic [5:0] fn);
    logic [5:0] key;
    key = (op == 6'h00) ? fn : 6'h3f;
    if (op == 6'h04 || op == 6'h05) return 4'b0010;
    case (op)
      6'h0a: key = 6'h2a;
      6'h0c: key = 6'h24;
      6'h0d: key = 6'h25;
      6'h0e: key = 6'h26;
      default: ;
    endcase
    case (key)
      6'h22: return 4'b0010;
      6'h24: return 4'b0100;
      6'h25: return 4'b0101;
      6'h26: return 4'b0110;
      6'h2a: return 4'b1010;
      default: return 4'b0000;
    endcase
  endfunction

  // vector {ir_load,pc_write,pc_src,reg_write,reg_dst,wb_src,mem_read,
  //         mem_write,alu_b_imm,ext_sign,alu_op,retire}
  function automatic logic [16:0] expect_vec(input logic [5:0] op, input logic [5:0] fn,
                                             input logic z, input int s);
    int k;
    logic il, pw, rw, rd, wb, mr, mw, bi, es, rt;
    logic [1:0] ps;
    logic [3:0] ao;
    k = klass(op, fn);
    {il, pw, rw, wb, mr, mw, bi, rt} = '0;
    ps = 2'b00; ao = 4'b0000;
    rd = (k == 1);
    es = (op == 6'h08 || op == 6'h0a || op == 6'h23 || op == 6'h2b ||
          op == 6'h04 || op == 6'h05);
    if (s == 0) begin il = 1; pw = 1; end
    else if (s == 1 && k == 6) begin pw = 1; ps = 2'b01; rt = 1; end
    else if (s == 2) begin
      ao = alu_code(op, fn);
      bi = (k == 2 || k == 3 || k == 4);
      if (k == 5) begin
        rt = 1;
        if ((op == 6'h04) ? z : !z) begin pw = 1; ps = 2'b10; end
      end
    end
    else if (s == 3) begin
      if (k == 1 || k == 2) begin rw = 1; rt = 1; end
      if (k == 4) begin mw = 1; rt = 1; end
      if (k == 3) mr = 1;
    end
    else if (s == 4) begin rw = 1; wb = 1; rt = 1; end
    return {il, pw, ps, rw, rd, wb, mr, mw, bi, es, ao, rt};
  endfunction

  function automatic string tag_of(input int k, input int s);
    if (s == 0) return "R2";
    case (k)
      6: return "R3";
      1, 2: return (s == 2) ? "R5" : "R4";
      3: return (s == 2) ? "R5" : "R7";
      4: return (s == 2) ? "R5" : "R8";
      5: return (s == 2) ? "R9" : "R6";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [16:0] got_vec();
    return {ir_load, pc_write, pc_src, reg_write, reg_dst, wb_src, mem_read,
            mem_write, alu_b_imm, ext_sign, alu_op, retire};
  endfunction

  task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp,
                       input logic [5:0] op, input logic [5:0] fn, input int s);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%h fn=%h step=%0d actual=%b expected=%b", tag, op, fn, s, got, exp);
    end
  endtask

  // runs one instruction; entered at a negedge in the fetch step
  task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input logic z);
    int n;
    int k;
    k = klass(op, fn);
    n = steps_of(k);
    opcode = op; funct = fn; alu_zero = z;
    for (int s = 0; s < n; s++) begin
      #1;
      check(tag_of(k, s), got_vec(), expect_vec(op, fn, z, s), op, fn, s);
      // R10: retire only on the final step
      check("R10", {16'b0, retire}, {16'b0, (s == n - 1) && (k != 0)}, op, fn, s);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check("R1", got_vec(), 17'b0, opcode, funct, 0);
    rst = 1'b0;
    // R1: first cycle after reset is a fetch step
    run_instr(6'h23, 6'h00, 1'b0);

    for (int op = 0; op < 64; op++) begin
      if (op == 0) begin
        for (int fn = 0; fn < 64; fn++)
          for (int z = 0; z < 2; z++)
            run_instr(6'(op), 6'(fn), z[0]);
      end else begin
        for (int z = 0; z < 2; z++)
          run_instr(6'(op), 6'(op) ^ 6'h15, z[0]);
      end
    end

    // R1: reset in the middle of a load
    opcode = 6'h23; funct = 6'h00; alu_zero = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check("R1", got_vec(), 17'b0, opcode, funct, 3);
    rst = 1'b0;
    run_instr(6'h2b, 6'h00, 1'b1);
    run_instr(6'h04, 6'h00, 1'b1);
    run_instr(6'h05, 6'h00, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule